// File: doc/BRIEF.md
# Sequence-Armed Watchdog Timer

This block is a hardware watchdog that pulls the system into reset when software stops servicing it. Software talks to it through two write-only registers: a key register and a period register. After any hardware reset the watchdog is idle and does not count. It starts only when the key register receives the byte 0x1E followed by the byte 0xE1. Once it is running, software cannot stop it. Software services it by writing the same two-byte key again before the selected interval runs out.

Time is counted in machine cycles, which a `cyc_tick` strobe marks. A fixed prescale stage of `PRE_W` bits feeds a programmable stage of `PROG_W` bits. The period field S selects a timeout of 2^(PRE_W+S) machine cycles. The defaults (14 and 7 bits) give a spread of about 128:1 between the shortest and longest timeout.

On timeout the block drives an active-high reset pulse. The pulse lasts `PULSE_LEN` periods of a separate oscillator strobe `osc_tick`, so its width does not depend on the machine-cycle divider. The pulse also disarms the watchdog and clears its counters, and it always runs to its full length.

Top module: `wdt_seq_timer`

## Requirements
- R1: After `rst_n` is asserted, `rst_pulse` is low, the watchdog is disarmed, the key detector is idle and the period field is 0. Asserting `rst_n` during a pulse ends the pulse at once.
- R2: A key-register write (`wr_en`=1, `wr_sel`=0) of 0x1E, followed by a key-register write of 0xE1 with no key-register write in between, arms the watchdog in the clock edge of the 0xE1 write.
- R3: Each of these writes returns the key detector to idle and does nothing else: a key-register write other than 0xE1 after 0x1E, and any first key byte other than 0x1E. Period-register writes (`wr_sel`=1) leave the key detector's state unchanged.
- R4: While armed, no register write disarms the watchdog. A wrong key byte does not restart the count.
- R5: A period-register write stores `wr_data[2:0]` as S. Once armed, `rst_pulse` rises 2^(PRE_W+S) `cyc_tick` cycles after the arming or servicing edge.
- R6: `rst_pulse` stays high for exactly `PULSE_LEN` `osc_tick` strobes, then falls.
- R7: A complete key sequence written while armed clears both counter stages. The next timeout is counted from the edge of its 0xE1 write.
- R8: An overflow disarms the watchdog and clears its counters. Key sequences written while the pulse is high are ignored. After the pulse ends the watchdog stays disarmed.
- R9: If a 0xE1 key write that completes a sequence falls in the same cycle as the terminal count, the service wins: no pulse starts, and a new interval begins.
- R10: The counters advance only in cycles where `cyc_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 = key register, 1 = period register |
| wr_data | input | 8 | Write data byte |
| cyc_tick | input | 1 | Machine-cycle strobe that advances the count |
| osc_tick | input | 1 | Oscillator-period strobe that times the reset pulse |
| rst_pulse | output | 1 | Active-high watchdog reset output |

## Verification
Two events can land on the same edge: the terminal count of the counter chain, and the 0xE1 write that completes a service sequence. The bench arms the watchdog at the shortest period and waits a fixed number of cycles. It then places the closing 0xE1 exactly on the terminal-count edge and checks that `rst_pulse` stays low and that a full new interval follows. It repeats the sequence one cycle late and checks that the pulse has already started and that the late key is ignored while the pulse runs.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    KEY_IDLE = 1'b0,
    KEY_HALF = 1'b1
  } key_state_e;

  localparam logic [7:0] KEY_OPEN  = 8'h1E;
  localparam logic [7:0] KEY_CLOSE = 8'hE1;
endpackage

// File: rtl/wdt_key_detect.sv
module wdt_key_detect
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic       kick
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    kick    = 1'b0;
    if (hold) begin
      state_d = KEY_IDLE;
    end else if (wr_en && !wr_sel) begin
      if (state_q == KEY_HALF && wr_data == KEY_CLOSE) begin
        kick    = 1'b1;
        state_d = KEY_IDLE;
      end else if (state_q == KEY_IDLE && wr_data == KEY_OPEN) begin
        state_d = KEY_HALF;
      end else begin
        state_d = KEY_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KEY_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/wdt_count_chain.sv
module wdt_count_chain #(
  parameter int PRE_W  = 14,
  parameter int PROG_W = 7,
  parameter int SEL_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [SEL_W-1:0] sel,
  output logic             full
);
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [PROG_W-1:0] prog_q, prog_d;
  logic [PROG_W-1:0] mask;
  logic              carry;

  always_comb begin
    for (int i = 0; i < PROG_W; i++) begin
      mask[i] = (i < int'(sel));
    end
  end

  assign carry = adv && (&pre_q);
  assign full  = carry && ((prog_q & mask) == mask);

  always_comb begin
    pre_d  = pre_q;
    prog_d = prog_q;
    if (clr) begin
      pre_d  = '0;
      prog_d = '0;
    end else if (adv) begin
      pre_d = pre_q + 1'b1;
      if (carry) prog_d = prog_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      prog_q <= '0;
    end else begin
      pre_q  <= pre_d;
      prog_q <= prog_d;
    end
  end
endmodule

// File: rtl/wdt_pulse_stretch.sv
module wdt_pulse_stretch #(
  parameter int PULSE_LEN = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic osc_tick,
  output logic active
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_q == '0) begin
      if (start) cnt_d = CNT_W'(PULSE_LEN);
    end else if (osc_tick) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/wdt_seq_timer.sv
module wdt_seq_timer #(
  parameter int PRE_W     = 14,
  parameter int PROG_W    = 7,
  parameter int PULSE_LEN = 96
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       cyc_tick,
  input  logic       osc_tick,
  output logic       rst_pulse
);
  localparam int SEL_W = $clog2(PROG_W + 1);

  logic             kick, full, ovf, clr, adv;
  logic             en_q, en_d;
  logic [SEL_W-1:0] sel_q, sel_d;

  wdt_key_detect u_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (rst_pulse),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .kick    (kick)
  );

  assign adv = en_q && cyc_tick;
  assign ovf = full && !kick;
  assign clr = kick || ovf || !en_q || rst_pulse;

  wdt_count_chain #(.PRE_W(PRE_W), .PROG_W(PROG_W), .SEL_W(SEL_W)) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .adv   (adv),
    .sel   (sel_q),
    .full  (full)
  );

  wdt_pulse_stretch #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (ovf),
    .osc_tick (osc_tick),
    .active   (rst_pulse)
  );

  always_comb begin
    en_d  = !(ovf || rst_pulse) && (en_q || kick);
    sel_d = (wr_en && wr_sel) ? wr_data[SEL_W-1:0] : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else begin
      en_q  <= en_d;
      sel_q <= sel_d;
    end
  end
endmodule

// File: rtl/wdt_seq_timer_chk.sv
module wdt_seq_timer_chk #(
  parameter int PULSE_LEN = 96
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic kick,
  input logic ovf,
  input logic osc_tick,
  input logic rst_pulse
);
  logic [15:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen_q <= '0;
    else if (rst_pulse) seen_q <= seen_q + {15'd0, osc_tick};
    else                seen_q <= '0;
  end

  AST_ARM_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> $past(kick)); // R2

  AST_NO_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ovf) |=> en); // R4

  AST_PULSE_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pulse) |-> $past(en)); // R5

  AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pulse && !osc_tick) |=> rst_pulse); // R6

  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_pulse) |-> (seen_q == 16'(PULSE_LEN))); // R6

  AST_DISARM_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> !en); // R8

  AST_SERVICE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !$rose(rst_pulse)); // R9
endmodule

bind wdt_seq_timer wdt_seq_timer_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en_q),
  .kick      (kick),
  .ovf       (ovf),
  .osc_tick  (osc_tick),
  .rst_pulse (rst_pulse)
);

// File: tb/tb_wdt_seq_timer.sv
`timescale 1ns/1ps
module tb_wdt_seq_timer;
  localparam int PRE_W = 4;
  localparam int PROG_W = 7;
  localparam int PULSE_LEN = 96;
  localparam int NV = 8;
  localparam int VEC_S [NV] = '{3, 0, 7, 1, 5, 2, 6, 4};
  localparam int VEC_T [NV] = '{128, 16, 2048, 32, 512, 64, 1024, 256};

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_sel, cyc_tick, osc_tick, osc_half;
  logic [7:0] wr_data;
  logic rst_pulse;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdt_seq_timer #(.PRE_W(PRE_W), .PROG_W(PROG_W), .PULSE_LEN(PULSE_LEN)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cyc_tick(cyc_tick), .osc_tick(osc_tick),
    .rst_pulse(rst_pulse)
  );

  always @(negedge clk) osc_tick <= osc_half ? ~osc_tick : 1'b1;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; the write is taken at the next posedge
  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
  endtask

  task automatic arm();
    wr(1'b0, 8'h1E);
    wr(1'b0, 8'hE1);
  endtask

  task automatic rise_after(output int n);
    n = 0;
    while (!rst_pulse && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic width(output int w);
    w = 0;
    while (rst_pulse && w < 1000) begin @(negedge clk); w++; end
  endtask

  task automatic quiet(input int len, output int hits);
    hits = 0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (rst_pulse) hits++;
    end
  endtask

  initial begin
    int n, w, h;
    rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0;
    cyc_tick = 1'b1; osc_half = 1'b0;
    repeat (3) @(negedge clk);
    chk(rst_pulse == 1'b0, "R1 pulse low in reset", rst_pulse, 0);
    rst_n = 1'b1;
    quiet(100, h);
    chk(h == 0, "R1 disarmed after reset", h, 0);

    // table: period select vs timeout and pulse width
    for (int i = 0; i < NV; i++) begin
      wr(1'b1, 8'(VEC_S[i]));
      arm();
      rise_after(n);
      chk(n == VEC_T[i], "R5 timeout for period field", n, VEC_T[i]);
      width(w);
      chk(w == PULSE_LEN, "R6 pulse width", w, PULSE_LEN);
    end
    wr(1'b1, 8'd0);

    // R3 bad sequences
    wr(1'b0, 8'h1E); wr(1'b0, 8'h55); wr(1'b0, 8'hE1);
    quiet(100, h);
    chk(h == 0, "R3 wrong second byte", h, 0);
    wr(1'b0, 8'h1E); wr(1'b0, 8'h1E); wr(1'b0, 8'hE1);
    quiet(100, h);
    chk(h == 0, "R3 doubled first byte", h, 0);
    wr(1'b0, 8'hE1);
    quiet(100, h);
    chk(h == 0, "R3 lone second byte", h, 0);
    wr(1'b0, 8'h1E); wr(1'b1, 8'd0); wr(1'b0, 8'hE1);
    rise_after(n);
    chk(n == 16, "R3 period write keeps key state", n, 16);
    width(w);

    // R4 no disarm, wrong key does not restart
    arm();
    wr(1'b0, 8'h00); wr(1'b0, 8'h1E); wr(1'b0, 8'h00); wr(1'b1, 8'd0);
    rise_after(n);
    chk(n == 12, "R4 cannot disarm or restart", n, 12);
    width(w);

    // R7 service
    arm();
    repeat (10) @(negedge clk);
    arm();
    rise_after(n);
    chk(n == 16, "R7 service restarts interval", n, 16);
    width(w);

    // R10 cyc_tick gating
    cyc_tick = 1'b0;
    arm();
    quiet(100, h);
    chk(h == 0, "R10 no advance without cyc_tick", h, 0);
    cyc_tick = 1'b1;
    rise_after(n);
    chk(n == 16, "R10 count resumes with cyc_tick", n, 16);
    width(w);

    // R9 service on terminal-count edge
    arm();
    repeat (14) @(negedge clk);
    wr(1'b0, 8'h1E); wr(1'b0, 8'hE1);
    chk(rst_pulse == 1'b0, "R9 service wins same cycle", rst_pulse, 0);
    rise_after(n);
    chk(n == 16, "R9 fresh interval after service", n, 16);
    width(w);

    // R8 one cycle late: pulse already running, key ignored
    arm();
    repeat (15) @(negedge clk);
    wr(1'b0, 8'h1E);
    chk(rst_pulse == 1'b1, "R8 late service too late", rst_pulse, 1);
    wr(1'b0, 8'hE1);
    width(w);
    chk(w == PULSE_LEN - 1, "R8 pulse runs full length", w, PULSE_LEN - 1);
    quiet(200, h);
    chk(h == 0, "R8 disarmed after pulse", h, 0);

    // R6 half-rate oscillator strobe
    osc_half = 1'b1;
    arm();
    rise_after(n);
    width(w);
    chk(w == 191 || w == 192, "R6 width in osc ticks", w, 192);
    osc_half = 1'b0;

    // R1 hardware reset mid-pulse clears pulse and period field
    wr(1'b1, 8'd3);
    arm();
    rise_after(n);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(rst_pulse == 1'b0, "R1 reset ends pulse", rst_pulse, 0);
    @(negedge clk);
    rst_n = 1'b1;
    quiet(200, h);
    chk(h == 0, "R1 disarmed after reset", h, 0);
    arm();
    rise_after(n);
    chk(n == 16, "R1 period field back to 0", n, 16);
    width(w);

    // R2 basic arming
    arm();
    @(negedge clk);
    chk(rst_pulse == 1'b0, "R2 no early pulse", rst_pulse, 0);
    rise_after(n);
    chk(n == 15, "R2 armed on close edge", n, 15);
    width(w);

    done = 1;
    summary();
  end
endmodule